// File: doc/BRIEF.md
# Flash page protection status logic

This block sits in front of a page-buffered flash array and decides, for every request, whether it may proceed. It enforces two rules. A buffer-ownership lock keeps a dirty page buffer from being silently replaced: once a write has landed in the buffer, a write to any other page is refused while the page-loss protect input is high, until the buffered page is discarded or programmed. A sticky per-page overwrite-protect flag, set by programming a page with the overwrite-protect input high, refuses writes, programs and erases to that page. The flag can only be removed by an unprotect operation on the page followed by a program with the overwrite-protect input low.

Each request gets a registered 2-bit status and a grant bit one cycle later. The current page-buffer tag is supplied from outside. The block does not program or erase the array itself.

Top module: `flash_page_guard`

## Requirements
- R1: After reset all overwrite-protect flags are clear, no page-loss lock is held, and resp_valid, grant and status read 0.
- R2: A request presented with req_valid is answered in the next cycle with resp_valid = 1; resp_valid is 0 in a cycle after no request; grant is 1 exactly when the returned status is 00.
- R3: Every granted write takes the page-loss lock. While the lock is held and pl_protect is 1, a write (op 0) to a page different from buf_page returns status 11 and is not granted.
- R4: A granted discard (op 4), or a granted program (op 1) of the page equal to buf_page, releases the lock, so a following write to another page with pl_protect = 1 returns 00.
- R5: A granted program with ow_protect = 1 sets that page's flag; afterwards a write, program or erase (ops 0, 1, 2) to the page returns status 01.
- R6: An unprotect (op 3) arms one page; a program of the armed page is granted, clears the arm, and stores the flag equal to ow_protect. A program of a protected, unarmed page and an erase of an armed protected page both return 01.
- R7: A write, program or erase to page RSVD_PAGE (default 0) returns status 10.
- R8: When several refusals apply, status 10 wins over 01, which wins over 11.
- R9: Ops 5 to 7 are granted with status 00 and change no flag or lock.
- R10: With pl_protect = 0, a write to a page other than buf_page is granted even while the lock is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation: 0 write, 1 program, 2 erase, 3 unprotect, 4 discard, 5-7 other |
| req_page | input | PW | Target page |
| buf_page | input | PW | Page currently held in the page buffer |
| pl_protect | input | 1 | Page-loss protect enable |
| ow_protect | input | 1 | Overwrite-protect value stored by a program |
| status | output | 2 | 00 ok, 01 protected page, 10 reserved page, 11 page-loss refusal |
| grant | output | 1 | Request allowed |
| resp_valid | output | 1 | status and grant are valid |

## Verification
The bench walks the unprotect-then-program sequence in its broken orders: a program without a prior unprotect, and an erase after an unprotect; a design that cleared the flag on unprotect alone would grant the erase. It checks that a write to the buffered page keeps succeeding under the lock while a foreign write gets 11, and that only discard or a program of the buffered page releases it; a design that freed the lock on any program would grant the foreign write early. Overlapping refusals on the reserved page and on a protected page under lock expose a wrong priority, and ops 5 to 7 on a protected page show whether they disturb the flag.

// File: rtl/flash_page_guard.sv
module flash_page_guard #(
  parameter int PAGES     = 16,
  parameter int RSVD_PAGE = 0,
  localparam int PW       = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [PW-1:0] req_page,
  input  logic [PW-1:0] buf_page,
  input  logic          pl_protect,
  input  logic          ow_protect,
  output logic [1:0]    status,
  output logic          grant,
  output logic          resp_valid
);
  localparam logic [2:0] OP_WRITE = 3'd0;
  localparam logic [2:0] OP_PROG  = 3'd1;
  localparam logic [2:0] OP_ERASE = 3'd2;
  localparam logic [2:0] OP_UNPR  = 3'd3;
  localparam logic [2:0] OP_DISC  = 3'd4;

  logic [PAGES-1:0] prot;
  logic             locked;
  logic             arm_v;
  logic [PW-1:0]    arm_page;
  logic [1:0]       code;

  wire is_mod   = (req_op == OP_WRITE) || (req_op == OP_PROG) || (req_op == OP_ERASE);
  wire is_rsvd  = (req_page == PW'(RSVD_PAGE));
  wire armed    = arm_v && (arm_page == req_page);
  wire ow_block = is_mod && prot[req_page] && !((req_op == OP_PROG) && armed);
  wire pl_block = (req_op == OP_WRITE) && pl_protect && locked && (req_page != buf_page);
  wire ok       = (code == 2'b00);
  wire take     = req_valid && ok;

  always_comb begin
    if (is_mod && is_rsvd)  code = 2'b10;
    else if (ow_block)      code = 2'b01;
    else if (pl_block)      code = 2'b11;
    else                    code = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      grant      <= 1'b0;
      status     <= 2'b00;
    end else begin
      resp_valid <= req_valid;
      grant      <= take;
      status     <= req_valid ? code : 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot     <= '0;
      locked   <= 1'b0;
      arm_v    <= 1'b0;
      arm_page <= '0;
    end else if (take) begin
      case (req_op)
        OP_WRITE: locked <= 1'b1;
        OP_PROG: begin
          prot[req_page] <= ow_protect;
          if (armed) arm_v <= 1'b0;
          if (req_page == buf_page) locked <= 1'b0;
        end
        OP_UNPR: begin
          arm_v    <= 1'b1;
          arm_page <= req_page;
        end
        OP_DISC: locked <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flash_page_guard_chk.sv
module flash_page_guard_chk #(
  parameter int PAGES     = 16,
  parameter int RSVD_PAGE = 0,
  localparam int PW       = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic [PW-1:0]    req_page,
  input logic [PW-1:0]    buf_page,
  input logic             pl_protect,
  input logic             ow_protect,
  input logic [1:0]       status,
  input logic             grant,
  input logic             resp_valid,
  input logic [PAGES-1:0] prot,
  input logic             locked,
  input logic             arm_v,
  input logic [PW-1:0]    arm_page
);
  wire c_mod   = req_op <= 3'd2;
  wire c_rsvd  = req_page == PW'(RSVD_PAGE);
  wire c_armed = arm_v && arm_page == req_page;

  a_r2_grant_iff_ok: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (grant == (status == 2'b00)));

  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid && !grant);

  a_r7_reserved_page: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && c_mod && c_rsvd |=> status == 2'b10);

  a_r5_protected_refused: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && c_mod && !c_rsvd && prot[req_page] && !(req_op == 3'd1 && c_armed)
    |=> status == 2'b01 && !grant);

  a_r3_page_loss: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 3'd0 && pl_protect && locked && req_page != buf_page
    && !prot[req_page] && !c_rsvd |=> status == 2'b11 && !grant);

  a_r6_program_stores_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 3'd1 && !c_rsvd && (!prot[req_page] || c_armed)
    |=> prot[$past(req_page)] == $past(ow_protect));
endmodule

bind flash_page_guard flash_page_guard_chk #(.PAGES(PAGES), .RSVD_PAGE(RSVD_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_page(req_page), .buf_page(buf_page), .pl_protect(pl_protect),
  .ow_protect(ow_protect), .status(status), .grant(grant),
  .resp_valid(resp_valid), .prot(prot), .locked(locked),
  .arm_v(arm_v), .arm_page(arm_page)
);

// File: tb/flash_page_guard_bench.sv
module flash_page_guard_bench;
  localparam int PW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, pl_protect = 1'b0, ow_protect = 1'b0;
  logic [2:0] req_op = '0;
  logic [PW-1:0] req_page = '0, buf_page = '0;
  logic [1:0] status;
  logic grant, resp_valid;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_page_guard u_flash_page_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_page(req_page), .buf_page(buf_page), .pl_protect(pl_protect),
    .ow_protect(ow_protect), .status(status), .grant(grant), .resp_valid(resp_valid)
  );

  task automatic check(string tag, logic [1:0] exp_st);
    logic exp_g = (exp_st == 2'b00);
    checks++;
    if (!resp_valid || status !== exp_st || grant !== exp_g) begin
      errors++;
      $display("FAIL %s: valid=%b status=%b grant=%b expected valid=1 status=%b grant=%b",
               tag, resp_valid, status, grant, exp_st, exp_g);
    end
  endtask

  task automatic req(string tag, logic [2:0] op, logic [PW-1:0] pg, logic pl, logic ow,
                     logic [1:0] exp_st);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_page = pg; pl_protect = pl; ow_protect = ow;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, exp_st);
  endtask

  task automatic t_reset();
    checks++;
    if (resp_valid !== 1'b0 || grant !== 1'b0 || status !== 2'b00) begin
      errors++;
      $display("FAIL R1: valid=%b grant=%b status=%b expected 0 0 00", resp_valid, grant, status);
    end
    req("R1 no initial lock", 3'd0, 4'd5, 1'b1, 1'b0, 2'b00);
    req("R1 cleanup discard", 3'd4, 4'd5, 1'b0, 1'b0, 2'b00);
    req("R1 flags clear", 3'd2, 4'd9, 1'b0, 1'b0, 2'b00);
    @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0 || grant !== 1'b0) begin
      errors++;
      $display("FAIL R2: idle valid=%b grant=%b expected 0 0", resp_valid, grant);
    end
  endtask

  task automatic t_page_loss();
    buf_page = 4'd3;
    req("R3 write buffered page", 3'd0, 4'd3, 1'b1, 1'b0, 2'b00);
    req("R3 foreign write refused", 3'd0, 4'd5, 1'b1, 1'b0, 2'b11);
    req("R10 unprotected foreign write", 3'd0, 4'd5, 1'b0, 1'b0, 2'b00);
    req("R3 still locked", 3'd0, 4'd7, 1'b1, 1'b0, 2'b11);
    req("R4 program other page keeps lock", 3'd1, 4'd8, 1'b1, 1'b0, 2'b00);
    req("R4 lock held after foreign program", 3'd0, 4'd7, 1'b1, 1'b0, 2'b11);
    req("R4 discard", 3'd4, 4'd3, 1'b1, 1'b0, 2'b00);
    req("R4 write after discard", 3'd0, 4'd5, 1'b1, 1'b0, 2'b00);
    buf_page = 4'd5;
    req("R4 program buffered page", 3'd1, 4'd5, 1'b1, 1'b0, 2'b00);
    req("R4 write after program", 3'd0, 4'd7, 1'b1, 1'b0, 2'b00);
    req("R4 cleanup discard", 3'd4, 4'd7, 1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_overwrite();
    buf_page = 4'd2;
    req("R5 program with protect", 3'd1, 4'd6, 1'b0, 1'b1, 2'b00);
    req("R5 write protected", 3'd0, 4'd6, 1'b0, 1'b0, 2'b01);
    req("R5 erase protected", 3'd2, 4'd6, 1'b0, 1'b0, 2'b01);
    req("R6 program without unprotect", 3'd1, 4'd6, 1'b0, 1'b0, 2'b01);
    req("R6 unprotect", 3'd3, 4'd6, 1'b0, 1'b0, 2'b00);
    req("R6 erase after unprotect", 3'd2, 4'd6, 1'b0, 1'b0, 2'b01);
    req("R6 program after unprotect", 3'd1, 4'd6, 1'b0, 1'b0, 2'b00);
    req("R6 erase cleared page", 3'd2, 4'd6, 1'b0, 1'b0, 2'b00);
    req("R6 reprotect", 3'd1, 4'd6, 1'b0, 1'b1, 2'b00);
    req("R6 arm consumed", 3'd1, 4'd6, 1'b0, 1'b0, 2'b01);
  endtask

  task automatic t_reserved_priority();
    buf_page = 4'd2;
    req("R7 write reserved", 3'd0, 4'd0, 1'b0, 1'b0, 2'b10);
    req("R7 program reserved", 3'd1, 4'd0, 1'b0, 1'b1, 2'b10);
    req("R7 erase reserved", 3'd2, 4'd0, 1'b0, 1'b0, 2'b10);
    req("R8 take lock", 3'd0, 4'd2, 1'b1, 1'b0, 2'b00);
    req("R8 protected beats page-loss", 3'd0, 4'd6, 1'b1, 1'b0, 2'b01);
    req("R8 reserved beats page-loss", 3'd0, 4'd0, 1'b1, 1'b0, 2'b10);
    req("R8 cleanup discard", 3'd4, 4'd2, 1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_other_ops();
    req("R9 op5 protected page", 3'd5, 4'd6, 1'b1, 1'b0, 2'b00);
    req("R9 op6", 3'd6, 4'd6, 1'b0, 1'b1, 2'b00);
    req("R9 op7", 3'd7, 4'd6, 1'b0, 1'b0, 2'b00);
    req("R9 flag unchanged", 3'd2, 4'd6, 1'b0, 1'b0, 2'b01);
    req("R9 no lock taken", 3'd0, 4'd11, 1'b1, 1'b0, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page_loss();
    t_overwrite();
    t_reserved_priority();
    t_other_ops();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule